// File: doc/BRIEF.md
# Priority-Pool Slave Arbiter

This block decides which of eight masters owns one shared slave port. Every master carries a two-bit priority level. Masters with equal levels form a pool. Between pools the higher level always wins. Level 3 (the top pool) and level 0 (the bottom pool) share access round-robin. Levels 1 and 2 (the middle pools) pick the highest-numbered requester.

A grant is registered and is held for the whole access. The arbiter decides again only when the current holder signals the end of its access with a one-cycle done pulse, or when no grant is held. While two or more masters are requesting, the master that held the last grant is left out of the next decision. Levels are loaded through a small write port. After reset every level is 0, so all masters start in plain round-robin.

Top module: `pool_arbiter`

## Requirements
- R1: After reset `gnt_vld_o` is 0, `gnt_o` is all zero, `gnt_idx_o` is 0, every level is 0, and both round-robin pointers sit at master 7.
- R2: A decision is taken on a rising edge only when no grant is held or `done_i` is 1. At any other edge the grant outputs keep their values.
- R3: A decision with at least one request grants a master whose request was high at that edge. A decision with no request clears `gnt_vld_o` and sets `gnt_idx_o` to 0 at that edge.
- R4: Among the masters that may win, the one with the highest level wins, whatever its master number.
- R5: When the winning level is 3, the winner is the first candidate found by searching upward from the top-pool pointer plus one, wrapping from 7 to 0. The pointer then moves to the winner. With two masters at level 3 requesting all the time, they alternate.
- R6: When the winning level is 0, the same search is made with a separate bottom-pool pointer. With all eight masters requesting at level 0 and done after every access, grants run 0,1,...,7,0.
- R7: When the winning level is 1 or 2, the candidate with the highest master number wins, and no pointer changes.
- R8: If more than one request is high at a decision, the master that held the previous grant cannot win. A master that is the only requester is granted again.
- R9: A write with `cfg_we_i`=1 stores `cfg_lvl_i` as the level of master `cfg_idx_i`. It does not change a grant that is being held, and it counts from the next decision on.
- R10: `gnt_o` is the one-hot decode of `gnt_idx_o` (bit i means master i) while `gnt_vld_o` is 1, and all zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Request line per master |
| done_i | input | 1 | One-cycle pulse at the end of the current access |
| cfg_we_i | input | 1 | Level write enable |
| cfg_idx_i | input | 3 | Master whose level is written |
| cfg_lvl_i | input | 2 | Level value to write |
| gnt_o | output | 8 | One-hot grant |
| gnt_vld_o | output | 1 | A grant is held |
| gnt_idx_o | output | 3 | Number of the granted master |

## Verification
All eight masters request at level 0 with done after every access. This shows the strict rotation in the bottom pool and tells it apart from a fixed-priority pick. Two top-level masters are then mixed with low-level traffic. This shows that the level decides first and that the top pool rotates on its own pointer. Three requesters in a middle pool show that the highest number wins there, and that the back-to-back rule is what hands the next grant to the runner-up. Single-requester and no-requester decisions separate a legal repeated grant from an idle drop. Random requests, done pulses and level writes, checked against a reference model in the bench, exercise holds, pointer updates and level writes that land in the middle of an access.

// File: rtl/pool_arb_pkg.sv
package pool_arb_pkg;

    typedef enum logic {
        PICK_RR   = 1'b0,
        PICK_HIGH = 1'b1
    } pick_mode_e;

endpackage

// File: rtl/level_regs.sv
module level_regs #(
    parameter int N_MST = 8,
    parameter int LVL_W = 2,
    localparam int IDX_W = $clog2(N_MST)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [IDX_W-1:0]       idx_i,
    input  logic [LVL_W-1:0]       lvl_i,
    output logic [N_MST*LVL_W-1:0] lvl_flat_o
);

    logic [N_MST-1:0][LVL_W-1:0] lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl_q;
        if (we_i) begin
            lvl_d[idx_i] = lvl_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign lvl_flat_o = lvl_q;

    // R9: a write lands in the addressed slot
    a_r9_level_write : assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> lvl_q[$past(idx_i)] == $past(lvl_i));

endmodule

// File: rtl/pick_unit.sv
module pick_unit #(
    parameter int N_MST = 8,
    parameter pool_arb_pkg::pick_mode_e MODE = pool_arb_pkg::PICK_RR,
    localparam int IDX_W = $clog2(N_MST)
) (
    input  logic [N_MST-1:0] mask_i,
    input  logic [IDX_W-1:0] ptr_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    generate
        if (MODE == pool_arb_pkg::PICK_RR) begin : g_rr
            always_comb begin
                found_o = 1'b0;
                idx_o   = '0;
                for (int k = 1; k <= N_MST; k++) begin
                    int pos;
                    pos = (int'(ptr_i) + k) % N_MST;
                    if (!found_o && mask_i[pos]) begin
                        found_o = 1'b1;
                        idx_o   = IDX_W'(pos);
                    end
                end
            end
        end else begin : g_high
            always_comb begin
                found_o = 1'b0;
                idx_o   = '0;
                for (int i = 0; i < N_MST; i++) begin
                    if (mask_i[i]) begin
                        found_o = 1'b1;
                        idx_o   = IDX_W'(i);
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/pool_select.sv
module pool_select #(
    parameter int N_MST = 8,
    parameter int LVL_W = 2,
    localparam int NLVL = 1 << LVL_W
) (
    input  logic [N_MST-1:0]       cand_i,
    input  logic [N_MST*LVL_W-1:0] lvl_flat_i,
    output logic [N_MST-1:0]       pool_mask_o,
    output logic [LVL_W-1:0]       top_lvl_o
);

    logic [N_MST-1:0][LVL_W-1:0] lvl;
    logic [NLVL-1:0][N_MST-1:0]  by_lvl;
    logic [NLVL-1:0]             lvl_hit;

    assign lvl = lvl_flat_i;

    genvar gl, gm;
    generate
        for (gl = 0; gl < NLVL; gl++) begin : g_lvl
            for (gm = 0; gm < N_MST; gm++) begin : g_mst
                assign by_lvl[gl][gm] = cand_i[gm] && (lvl[gm] == LVL_W'(gl));
            end
            assign lvl_hit[gl] = |by_lvl[gl];
        end
    endgenerate

    always_comb begin
        top_lvl_o = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (lvl_hit[l]) begin
                top_lvl_o = LVL_W'(l);
            end
        end
        pool_mask_o = by_lvl[top_lvl_o];
    end

endmodule

// File: rtl/pool_arbiter.sv
module pool_arbiter #(
    parameter int N_MST = 8,
    parameter int LVL_W = 2,
    localparam int IDX_W = $clog2(N_MST),
    localparam logic [LVL_W-1:0] LVL_TOP = {LVL_W{1'b1}}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MST-1:0] req_i,
    input  logic             done_i,
    input  logic             cfg_we_i,
    input  logic [IDX_W-1:0] cfg_idx_i,
    input  logic [LVL_W-1:0] cfg_lvl_i,
    output logic [N_MST-1:0] gnt_o,
    output logic             gnt_vld_o,
    output logic [IDX_W-1:0] gnt_idx_o
);

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
        logic             last_vld;
        logic [IDX_W-1:0] last;
        logic [IDX_W-1:0] ptr_hi;
        logic [IDX_W-1:0] ptr_lo;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [N_MST*LVL_W-1:0] lvl_flat;
    logic [N_MST-1:0]       cand;
    logic [N_MST-1:0]       pool_mask;
    logic [LVL_W-1:0]       top_lvl;
    logic                   hi_found, lo_found, fx_found;
    logic [IDX_W-1:0]       hi_idx, lo_idx, fx_idx;
    logic                   arb_now;

    level_regs #(.N_MST(N_MST), .LVL_W(LVL_W)) u_lvl (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (cfg_we_i),
        .idx_i      (cfg_idx_i),
        .lvl_i      (cfg_lvl_i),
        .lvl_flat_o (lvl_flat)
    );

    // the previous winner is left out while others are asking
    always_comb begin
        cand = req_i;
        if (st_q.last_vld && ($countones(req_i) > 1)) begin
            cand[st_q.last] = 1'b0;
        end
    end

    pool_select #(.N_MST(N_MST), .LVL_W(LVL_W)) u_sel (
        .cand_i      (cand),
        .lvl_flat_i  (lvl_flat),
        .pool_mask_o (pool_mask),
        .top_lvl_o   (top_lvl)
    );

    pick_unit #(.N_MST(N_MST), .MODE(pool_arb_pkg::PICK_RR)) u_rr_hi (
        .mask_i  (pool_mask),
        .ptr_i   (st_q.ptr_hi),
        .found_o (hi_found),
        .idx_o   (hi_idx)
    );

    pick_unit #(.N_MST(N_MST), .MODE(pool_arb_pkg::PICK_RR)) u_rr_lo (
        .mask_i  (pool_mask),
        .ptr_i   (st_q.ptr_lo),
        .found_o (lo_found),
        .idx_o   (lo_idx)
    );

    pick_unit #(.N_MST(N_MST), .MODE(pool_arb_pkg::PICK_HIGH)) u_fx (
        .mask_i  (pool_mask),
        .ptr_i   (st_q.ptr_lo),
        .found_o (fx_found),
        .idx_o   (fx_idx)
    );

    assign arb_now = !st_q.vld || done_i;

    always_comb begin
        st_d = st_q;
        if (arb_now) begin
            if (top_lvl == LVL_TOP && hi_found) begin
                st_d.vld      = 1'b1;
                st_d.idx      = hi_idx;
                st_d.ptr_hi   = hi_idx;
                st_d.last     = hi_idx;
                st_d.last_vld = 1'b1;
            end else if (top_lvl == '0 && lo_found) begin
                st_d.vld      = 1'b1;
                st_d.idx      = lo_idx;
                st_d.ptr_lo   = lo_idx;
                st_d.last     = lo_idx;
                st_d.last_vld = 1'b1;
            end else if (top_lvl != LVL_TOP && top_lvl != '0 && fx_found) begin
                st_d.vld      = 1'b1;
                st_d.idx      = fx_idx;
                st_d.last     = fx_idx;
                st_d.last_vld = 1'b1;
            end else begin
                st_d.vld = 1'b0;
                st_d.idx = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.vld      <= 1'b0;
            st_q.idx      <= '0;
            st_q.last_vld <= 1'b0;
            st_q.last     <= '0;
            st_q.ptr_hi   <= IDX_W'(N_MST - 1);
            st_q.ptr_lo   <= IDX_W'(N_MST - 1);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        gnt_o = '0;
        if (st_q.vld) begin
            gnt_o[st_q.idx] = 1'b1;
        end
    end

    assign gnt_vld_o = st_q.vld;
    assign gnt_idx_o = st_q.idx;

    // R2: grant frozen while an access runs
    a_r2_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld_o && !done_i) |=> (gnt_vld_o && $stable(gnt_idx_o)));

    // R3: a decision serves only a requester
    a_r3_to_requester : assert property (@(posedge clk) disable iff (!rst_n)
        (arb_now && (|req_i)) |=> ((gnt_o & $past(req_i)) != '0));

    // R3: no request at a decision means no grant
    a_r3_drop : assert property (@(posedge clk) disable iff (!rst_n)
        (arb_now && (req_i == '0)) |=> !gnt_vld_o);

    // R8: no repeat while others wait
    a_r8_no_repeat : assert property (@(posedge clk) disable iff (!rst_n)
        (arb_now && st_q.last_vld && ($countones(req_i) > 1))
        |=> (gnt_idx_o != $past(st_q.last)));

    // R10: grant vector matches index
    a_r10_onehot : assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld_o |-> ($onehot(gnt_o) && gnt_o[gnt_idx_o]));

    a_r10_idle_zero : assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_vld_o |-> (gnt_o == '0));

endmodule

// File: tb/pool_arbiter_tb.sv
module pool_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req = '0;
    logic       done = 1'b0;
    logic       we = 1'b0;
    logic [2:0] widx = '0;
    logic [1:0] wlvl = '0;
    logic [7:0] gnt;
    logic       gvld;
    logic [2:0] gidx;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference model state
    int  m_lvl[8];
    int  m_last;
    bit  m_last_vld;
    int  m_phi, m_plo;
    bit  m_vld;
    int  m_idx;

    always #10 clk = ~clk;

    pool_arbiter dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req),
        .done_i    (done),
        .cfg_we_i  (we),
        .cfg_idx_i (widx),
        .cfg_lvl_i (wlvl),
        .gnt_o     (gnt),
        .gnt_vld_o (gvld),
        .gnt_idx_o (gidx)
    );

    task automatic chk(input string tag, input bit ok, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int rr_find(input logic [7:0] m, input int p);
        for (int k = 1; k <= 8; k++) begin
            if (m[(p + k) % 8]) return (p + k) % 8;
        end
        return -1;
    endfunction

    function automatic int hi_find(input logic [7:0] m);
        for (int i = 7; i >= 0; i--) begin
            if (m[i]) return i;
        end
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_lvl[i] = 0;
        m_last = 0; m_last_vld = 0; m_phi = 7; m_plo = 7; m_vld = 0; m_idx = 0;
    endtask

    task automatic model_step(input logic [7:0] rq, input bit dn, input bit w,
                              input int wi, input int wl);
        if (!m_vld || dn) begin
            logic [7:0] c;
            int top, win;
            c = rq;
            if (m_last_vld && $countones(rq) > 1) c[m_last] = 1'b0;
            if (c == 0) begin
                m_vld = 0; m_idx = 0;
            end else begin
                logic [7:0] pm;
                top = 0;
                for (int i = 0; i < 8; i++) if (c[i] && m_lvl[i] > top) top = m_lvl[i];
                pm = '0;
                for (int i = 0; i < 8; i++) pm[i] = c[i] && (m_lvl[i] == top);
                if (top == 3) begin win = rr_find(pm, m_phi); m_phi = win; end
                else if (top == 0) begin win = rr_find(pm, m_plo); m_plo = win; end
                else win = hi_find(pm);
                m_vld = 1; m_idx = win; m_last = win; m_last_vld = 1;
            end
        end
        if (w) m_lvl[wi] = wl;
    endtask

    task automatic step(input logic [7:0] rq, input bit dn, input bit w,
                        input int wi, input int wl, input string tag);
        @(negedge clk);
        req = rq; done = dn; we = w; widx = 3'(wi); wlvl = 2'(wl);
        model_step(rq, dn, w, wi, wl);
        @(posedge clk);
        #1;
        chk({tag, " valid"}, gvld == m_vld, int'(gvld), int'(m_vld));
        chk({tag, " index"}, int'(gidx) == m_idx, int'(gidx), m_idx);
        chk({tag, " onehot"}, gnt == (m_vld ? 8'(1 << m_idx) : 8'h00), int'(gnt),
            m_vld ? (1 << m_idx) : 0);
    endtask

    task automatic expect_gnt(input string tag, input int idx);
        chk(tag, gvld && int'(gidx) == idx, gvld ? int'(gidx) : -1, idx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 valid", gvld == 1'b0, int'(gvld), 0);
        chk("R1 grant", gnt == 8'h00, int'(gnt), 0);
        chk("R1 index", gidx == 3'd0, int'(gidx), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: bottom pool rotation 0..7,0
        for (int n = 0; n < 9; n++) begin
            step(8'hFF, n != 0, 0, 0, 0, "R6");
            expect_gnt("R6 rotation", n % 8);
        end

        // R2 / R9: hold without done; a level write does not disturb it
        step(8'h0F, 0, 1, 5, 3, "R9");
        expect_gnt("R9 hold on write", 0);
        step(8'hF0, 0, 1, 2, 3, "R2");
        expect_gnt("R2 hold", 0);
        step(8'h00, 0, 0, 0, 0, "R2");
        expect_gnt("R2 hold no req", 0);

        // R3: decision with no request drops grant
        step(8'h00, 1, 0, 0, 0, "R3");
        chk("R3 drop", gvld == 1'b0, int'(gvld), 0);

        // R5 / R4: masters 2 and 5 at top level beat all others, alternate
        step(8'hFF, 0, 0, 0, 0, "R4");
        expect_gnt("R4 top pool wins", 2);
        step(8'hFF, 1, 0, 0, 0, "R5");
        expect_gnt("R5 alternate", 5);
        step(8'hFF, 1, 0, 0, 0, "R5");
        expect_gnt("R5 alternate back", 2);
        step(8'h00, 1, 1, 2, 0, "R3");
        step(8'h00, 0, 1, 5, 0, "R9");
        step(8'h00, 0, 1, 1, 1, "R9");
        step(8'h00, 0, 1, 4, 1, "R9");
        step(8'h00, 0, 1, 6, 1, "R9");

        // R7 / R8: middle pool, highest number, then runner-up
        step(8'h52, 0, 0, 0, 0, "R7");
        expect_gnt("R7 highest number", 6);
        step(8'h52, 1, 0, 0, 0, "R8");
        expect_gnt("R8 excluded last", 4);
        step(8'h52, 1, 0, 0, 0, "R7");
        expect_gnt("R7 highest again", 6);

        // R8: sole requester repeats
        step(8'h08, 1, 0, 0, 0, "R8");
        expect_gnt("R8 sole", 3);
        step(8'h08, 1, 0, 0, 0, "R8");
        expect_gnt("R8 sole repeat", 3);
        step(8'h00, 1, 0, 0, 0, "R3");
        chk("R3 idle", gvld == 1'b0, int'(gvld), 0);

        // random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] rq;
            bit dn, w;
            rq = 8'($urandom) & 8'($urandom | $urandom);
            dn = ($urandom % 3) != 0;
            w  = ($urandom % 8) == 0;
            step(rq, dn, w, int'($urandom % 8), int'($urandom % 4), "R4");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule